// File: doc/BRIEF.md
# Paged Program Counter and Branch Target Unit

This block holds the 12-bit program counter of a small 8-bit controller whose code space is divided into two 2K banks, and computes the next PC for every executed instruction. A decoder upstream reduces each instruction to a class code and hands over the opcode byte, the optional second byte, the accumulator, a set of condition inputs and a register value. The unit then advances the PC or jumps, and reports whether a jump was taken.

Bank selection is deferred. A bank-select instruction only records a pending bank bit. That bit enters PC bit 11 at the next long jump, and plain increments never carry out of bit 10. Short conditional jumps, accumulator jumps and table reads all work inside the 256-byte page of the address that follows the opcode byte.

Table reads produce an address on a valid/ready output stream. The address stays presented, unchanged, until the consumer takes it. While it waits, `ins_ready` is low and no instruction is accepted. A new table read may be accepted in the same cycle that the old address is taken.

Top module: `pcj_unit`

## Requirements
- R1: After reset, `pc` is 0, `taken` and `tf_clear` are 0, `tbl_valid` is 0, `ins_ready` is 1 and the pending bank bit is 0.
- R2: An instruction of class 0 (sequential) moves the PC on by 2 when `ins_two` is 1 and by 1 otherwise. Increments wrap within bits 10:0 and leave bit 11 unchanged, so 0x7FF+1 gives 0x000 and 0xFFF+2 gives 0x801. `taken` is 0 afterwards.
- R3: Class 1 (long jump) loads the PC with {pending bank bit, opcode bits 7:5, second byte} and raises `taken` for one cycle.
- R4: Class 2 (bank select) stores opcode bit 4 as the pending bank bit and advances the PC by 1 without changing PC bit 11.
- R5: Class 3 (conditional) is taken when `cond_vec[cond_sel]` is 1. A taken jump gives {bits 11:8 of PC+1, second byte}. A jump that is not taken gives PC+2.
- R6: Class 4 (accumulator-bit test) is taken when the accumulator bit numbered by opcode bits 7:5 is 1. The target and fall-through rules are those of R5.
- R7: `reg_dec` always equals `reg_val`−1 modulo 256. Class 5 (decrement-and-jump) is taken when that value is non-zero, with the target rules of R5.
- R8: Class 6 (timer-flag jump) is taken when `timer_flag` is 1, and then `tf_clear` pulses in the same cycle as `taken`. When the flag is 0, neither pulses.
- R9: Class 7 (accumulator jump) always jumps, to {bits 11:8 of PC+1, `acc`}.
- R10: Class 8 (in-page table read) presents {bits 11:8 of PC+1, `acc`} on `tbl_addr` with `tbl_valid` high, and advances the PC by 1.
- R11: Class 9 (fixed table read) presents 0x300+`acc` on `tbl_addr` and advances the PC by 1.
- R12: While `tbl_valid` is 1 and `tbl_ready` is 0, `ins_ready` is 0, offered instructions leave the PC unchanged, and `tbl_addr` holds. A table read accepted in the handshake cycle replaces the address and keeps `tbl_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction offered |
| ins_ready | output | 1 | Instruction accepted this cycle when valid |
| ins_class | input | 4 | Instruction class code |
| ins_op | input | 8 | Opcode byte |
| ins_arg | input | 8 | Second instruction byte |
| ins_two | input | 1 | Sequential instruction is two bytes long |
| acc | input | 8 | Accumulator value |
| cond_vec | input | NCOND | Condition inputs for class 3 |
| cond_sel | input | SEL_W | Index into `cond_vec` |
| reg_val | input | 8 | Register value for decrement-and-jump |
| timer_flag | input | 1 | Timer overflow flag |
| reg_dec | output | 8 | Decremented register value |
| pc | output | 12 | Program counter |
| taken | output | 1 | Jump taken by the previous accepted instruction |
| tf_clear | output | 1 | Request to clear the timer flag |
| tbl_valid | output | 1 | Table address valid |
| tbl_ready | input | 1 | Table address consumed |
| tbl_addr | output | 12 | Table read address |

## Verification
Two events can fall in the same clock edge: the table stream handing off a waiting address, and the acceptance of a new instruction. The bench holds a page table read stalled, then offers a fixed table read while raising `tbl_ready`. It expects `tbl_valid` to stay high with the new address 0x300+acc and the PC to advance once, with no idle gap. The bench also steps a conditional jump from the last byte of a page, where the target page must be taken from PC+1 rather than from the current PC.

// File: rtl/pcj_pkg.sv
`timescale 1ns/1ps
package pcj_pkg;
  localparam int PC_W   = 12;
  localparam int BYTE_W = 8;
  localparam int LOW_W  = PC_W - 1;
  localparam int PAGE_W = PC_W - BYTE_W;

  typedef enum logic [3:0] {
    CLS_SEQ    = 4'd0,
    CLS_LJMP   = 4'd1,
    CLS_BANK   = 4'd2,
    CLS_CJMP   = 4'd3,
    CLS_JBIT   = 4'd4,
    CLS_DJNZ   = 4'd5,
    CLS_JTF    = 4'd6,
    CLS_JACC   = 4'd7,
    CLS_TBL_PG = 4'd8,
    CLS_TBL_FX = 4'd9
  } pcj_class_e;

  // Advance within the current bank: bit 11 never changes.
  function automatic logic [PC_W-1:0] bump(input logic [PC_W-1:0] p, input logic [1:0] n);
    logic [LOW_W-1:0] low;
    low = p[LOW_W-1:0] + LOW_W'(n);
    return {p[PC_W-1], low};
  endfunction
endpackage

// File: rtl/pcj_cond.sv
`timescale 1ns/1ps
module pcj_cond #(
  parameter int NCOND = 4,
  localparam int SEL_W = (NCOND > 1) ? $clog2(NCOND) : 1
) (
  input  pcj_pkg::pcj_class_e cls,
  input  logic [7:0]          op,
  input  logic [7:0]          acc,
  input  logic [NCOND-1:0]    cond_vec,
  input  logic [SEL_W-1:0]    cond_sel,
  input  logic [7:0]          reg_val,
  input  logic                timer_flag,
  output logic [7:0]          reg_dec,
  output logic                take
);
  import pcj_pkg::*;

  assign reg_dec = reg_val - 8'd1;

  always_comb begin
    unique case (cls)
      CLS_LJMP, CLS_JACC: take = 1'b1;
      CLS_CJMP:           take = cond_vec[cond_sel];
      CLS_JBIT:           take = acc[op[7:5]];
      CLS_DJNZ:           take = (reg_dec != 8'd0);
      CLS_JTF:            take = timer_flag;
      default:            take = 1'b0;
    endcase
  end
endmodule

// File: rtl/pcj_target.sv
`timescale 1ns/1ps
module pcj_target #(
  parameter logic [pcj_pkg::PC_W-1:0] TBL_BASE = 12'h300
) (
  input  pcj_pkg::pcj_class_e         cls,
  input  logic [7:0]                  op,
  input  logic [7:0]                  arg,
  input  logic [7:0]                  acc,
  input  logic                        two,
  input  logic                        take,
  input  logic                        pend,
  input  logic [pcj_pkg::PC_W-1:0]    pc,
  output logic [pcj_pkg::PC_W-1:0]    pc_next,
  output logic                        tbl_load,
  output logic [pcj_pkg::PC_W-1:0]    tbl_next
);
  import pcj_pkg::*;

  logic [PC_W-1:0]   pc1, pc2;
  logic [PAGE_W-1:0] page;

  assign pc1  = bump(pc, 2'd1);
  assign pc2  = bump(pc, 2'd2);
  assign page = pc1[PC_W-1:BYTE_W];

  always_comb begin
    tbl_load = 1'b0;
    tbl_next = {page, acc};
    unique case (cls)
      CLS_LJMP: pc_next = {pend, op[7:5], arg};
      CLS_BANK: pc_next = pc1;
      CLS_CJMP, CLS_JBIT, CLS_DJNZ, CLS_JTF:
                pc_next = take ? {page, arg} : pc2;
      CLS_JACC: pc_next = {page, acc};
      CLS_TBL_PG: begin
        pc_next  = pc1;
        tbl_load = 1'b1;
      end
      CLS_TBL_FX: begin
        pc_next  = pc1;
        tbl_load = 1'b1;
        tbl_next = TBL_BASE + PC_W'(acc);
      end
      default:  pc_next = two ? pc2 : pc1;
    endcase
  end
endmodule

// File: rtl/pcj_unit.sv
`timescale 1ns/1ps
module pcj_unit #(
  parameter int NCOND = 4,
  parameter logic [11:0] TBL_BASE = 12'h300,
  localparam int SEL_W = (NCOND > 1) ? $clog2(NCOND) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  output logic             ins_ready,
  input  logic [3:0]       ins_class,
  input  logic [7:0]       ins_op,
  input  logic [7:0]       ins_arg,
  input  logic             ins_two,
  input  logic [7:0]       acc,
  input  logic [NCOND-1:0] cond_vec,
  input  logic [SEL_W-1:0] cond_sel,
  input  logic [7:0]       reg_val,
  input  logic             timer_flag,
  output logic [7:0]       reg_dec,
  output logic [11:0]      pc,
  output logic             taken,
  output logic             tf_clear,
  output logic             tbl_valid,
  input  logic             tbl_ready,
  output logic [11:0]      tbl_addr
);
  import pcj_pkg::*;

  pcj_class_e      cls;
  logic            accept, take, tbl_load, pend_q;
  logic [PC_W-1:0] pc_q, pc_next, tbl_next;

  assign cls       = pcj_class_e'(ins_class);
  assign ins_ready = !tbl_valid || tbl_ready;
  assign accept    = ins_valid && ins_ready;
  assign pc        = pc_q;

  pcj_cond #(.NCOND(NCOND)) u_cond (
    .cls(cls), .op(ins_op), .acc(acc), .cond_vec(cond_vec), .cond_sel(cond_sel),
    .reg_val(reg_val), .timer_flag(timer_flag), .reg_dec(reg_dec), .take(take)
  );

  pcj_target #(.TBL_BASE(TBL_BASE)) u_tgt (
    .cls(cls), .op(ins_op), .arg(ins_arg), .acc(acc), .two(ins_two), .take(take),
    .pend(pend_q), .pc(pc_q), .pc_next(pc_next), .tbl_load(tbl_load), .tbl_next(tbl_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q      <= '0;
      pend_q    <= 1'b0;
      taken     <= 1'b0;
      tf_clear  <= 1'b0;
      tbl_valid <= 1'b0;
      tbl_addr  <= '0;
    end else begin
      taken    <= accept && take;
      tf_clear <= accept && take && (cls == CLS_JTF);
      if (accept) begin
        pc_q <= pc_next;
        if (cls == CLS_BANK) pend_q <= ins_op[4];
      end
      if (accept && tbl_load) begin
        tbl_valid <= 1'b1;
        tbl_addr  <= tbl_next;
      end else if (tbl_ready) begin
        tbl_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pcj_unit_chk.sv
`timescale 1ns/1ps
module pcj_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ins_valid,
  input logic        ins_ready,
  input logic [3:0]  ins_class,
  input logic [7:0]  ins_op,
  input logic [7:0]  ins_arg,
  input logic [11:0] pc,
  input logic        taken,
  input logic        tf_clear,
  input logic        tbl_valid,
  input logic        tbl_ready,
  input logic [11:0] tbl_addr
);
  logic acc_ok;
  assign acc_ok = ins_valid && ins_ready;

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_ok |=> !taken && $stable(pc));

  assert_seq_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok && ins_class == 4'd0 |=> pc[11] == $past(pc[11]) && !taken);

  assert_ljmp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok && ins_class == 4'd1 |=> pc[10:0] == $past({ins_op[7:5], ins_arg}) && taken);

  assert_tfc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tf_clear |-> taken);

  assert_fixed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok && ins_class == 4'd9 |=> tbl_valid && tbl_addr[11:8] == 4'h3);

  assert_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_valid && !tbl_ready |-> !ins_ready);

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_valid && !tbl_ready |=> tbl_valid && $stable(tbl_addr) && $stable(pc));
endmodule

bind pcj_unit pcj_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
  .ins_class(ins_class), .ins_op(ins_op), .ins_arg(ins_arg), .pc(pc),
  .taken(taken), .tf_clear(tf_clear), .tbl_valid(tbl_valid),
  .tbl_ready(tbl_ready), .tbl_addr(tbl_addr)
);

// File: tb/sim_pcj_unit.sv
`timescale 1ns/1ps
module sim_pcj_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0, ins_ready, ins_two = 1'b0;
  logic [3:0]  ins_class = '0;
  logic [7:0]  ins_op = '0, ins_arg = '0, acc = '0, reg_val = '0, reg_dec;
  logic [3:0]  cond_vec = '0;
  logic [1:0]  cond_sel = '0;
  logic        timer_flag = 1'b0, taken, tf_clear, tbl_valid, tbl_ready = 1'b1;
  logic [11:0] pc, tbl_addr;
  logic [11:0] epc;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  pcj_unit u0 (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_class(ins_class), .ins_op(ins_op), .ins_arg(ins_arg), .ins_two(ins_two),
    .acc(acc), .cond_vec(cond_vec), .cond_sel(cond_sel), .reg_val(reg_val),
    .timer_flag(timer_flag), .reg_dec(reg_dec), .pc(pc), .taken(taken),
    .tf_clear(tf_clear), .tbl_valid(tbl_valid), .tbl_ready(tbl_ready), .tbl_addr(tbl_addr)
  );

  function automatic logic [11:0] adv(input logic [11:0] p, input int n);
    logic [10:0] low;
    low = p[10:0] + 11'(n);
    return {p[11], low};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] c, input logic [7:0] o, input logic [7:0] a, input logic two);
    @(negedge clk);
    ins_class = c; ins_op = o; ins_arg = a; ins_two = two; ins_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ins_valid = 1'b0;
  endtask

  task automatic cjump(input string tag, input logic [3:0] c, input logic [7:0] o,
                       input logic [7:0] a, input logic tk);
    logic [11:0] nxt;
    nxt = adv(epc, 1);
    nxt = tk ? {nxt[11:8], a} : adv(epc, 2);
    issue(c, o, a, 1'b0);
    check({tag, " pc"}, pc, nxt);
    check({tag, " taken"}, taken, tk);
    epc = nxt;
  endtask

  task automatic t_reset;
    check("R1 pc", pc, 0);
    check("R1 taken", taken, 0);
    check("R1 tf_clear", tf_clear, 0);
    check("R1 tbl_valid", tbl_valid, 0);
    check("R1 ins_ready", ins_ready, 1);
    issue(4'd1, 8'hA0, 8'h12, 1'b0);
    check("R1 pending bank zero", pc, 12'h512);
    epc = 12'h512;
  endtask

  task automatic t_seq;
    issue(4'd0, 8'h00, 8'h00, 1'b0); epc = adv(epc, 1);
    check("R2 step1", pc, epc);
    check("R2 no taken", taken, 0);
    issue(4'd0, 8'h00, 8'h00, 1'b1); epc = adv(epc, 2);
    check("R2 step2", pc, epc);
    issue(4'd1, 8'hE0, 8'hFF, 1'b0);
    check("R3 ljmp", pc, 12'h7FF);
    check("R3 taken", taken, 1);
    issue(4'd0, 8'h00, 8'h00, 1'b0);
    check("R2 wrap 7FF", pc, 12'h000);
  endtask

  task automatic t_bank;
    issue(4'd2, 8'h10, 8'h00, 1'b0);
    check("R4 bank sel pc", pc, 12'h001);
    issue(4'd1, 8'hE0, 8'hFF, 1'b0);
    check("R3 R4 ljmp bank1", pc, 12'hFFF);
    issue(4'd0, 8'h00, 8'h00, 1'b1);
    check("R2 wrap FFF", pc, 12'h801);
    issue(4'd2, 8'hEF, 8'h00, 1'b0);
    check("R4 bit11 kept", pc, 12'h802);
    issue(4'd1, 8'h20, 8'h34, 1'b0);
    check("R3 R4 ljmp bank0", pc, 12'h134);
    epc = 12'h134;
  endtask

  task automatic t_cond;
    cond_vec = 4'b0100; cond_sel = 2'd2;
    cjump("R5 taken", 4'd3, 8'h00, 8'h50, 1'b1);
    cond_sel = 2'd1;
    cjump("R5 not taken", 4'd3, 8'h00, 8'h50, 1'b0);
    issue(4'd1, 8'h00, 8'hFF, 1'b0); epc = 12'h0FF;
    cond_sel = 2'd2;
    cjump("R5 page edge", 4'd3, 8'h00, 8'h10, 1'b1);
    check("R5 page edge abs", pc, 12'h110);
  endtask

  task automatic t_jbit;
    acc = 8'h20;
    cjump("R6 bit5 set", 4'd4, 8'hA0, 8'h66, 1'b1);
    cjump("R6 bit6 clear", 4'd4, 8'hC0, 8'h66, 1'b0);
  endtask

  task automatic t_djnz;
    reg_val = 8'h01; #1;
    check("R7 dec 1", reg_dec, 8'h00);
    cjump("R7 reaches zero", 4'd5, 8'h00, 8'h22, 1'b0);
    reg_val = 8'h00; #1;
    check("R7 dec wrap", reg_dec, 8'hFF);
    cjump("R7 nonzero", 4'd5, 8'h00, 8'h22, 1'b1);
  endtask

  task automatic t_jtf;
    timer_flag = 1'b1;
    cjump("R8 flag set", 4'd6, 8'h00, 8'h90, 1'b1);
    check("R8 tf_clear", tf_clear, 1);
    timer_flag = 1'b0;
    cjump("R8 flag clear", 4'd6, 8'h00, 8'h90, 1'b0);
    check("R8 no clear", tf_clear, 0);
  endtask

  task automatic t_jacc;
    logic [11:0] p1;
    acc = 8'h77;
    p1 = adv(epc, 1);
    issue(4'd7, 8'h00, 8'h00, 1'b0);
    epc = {p1[11:8], 8'h77};
    check("R9 jacc", pc, epc);
    check("R9 taken", taken, 1);
  endtask

  task automatic t_table;
    logic [11:0] p1;
    tbl_ready = 1'b0; acc = 8'h42;
    p1 = adv(epc, 1);
    issue(4'd8, 8'h00, 8'h00, 1'b0);
    epc = p1;
    check("R10 valid", tbl_valid, 1);
    check("R10 addr", tbl_addr, {p1[11:8], 8'h42});
    check("R10 pc", pc, epc);
    check("R12 ready low", ins_ready, 0);
    issue(4'd0, 8'h00, 8'h00, 1'b1);
    check("R12 pc frozen", pc, epc);
    check("R12 addr held", tbl_addr, {p1[11:8], 8'h42});
    check("R12 valid held", tbl_valid, 1);
    acc = 8'hFE;
    @(negedge clk);
    ins_class = 4'd9; ins_valid = 1'b1; tbl_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ins_valid = 1'b0;
    epc = adv(epc, 1);
    check("R11 R12 reload valid", tbl_valid, 1);
    check("R11 fixed addr", tbl_addr, 12'h3FE);
    check("R11 pc", pc, epc);
    @(negedge clk);
    check("R12 drained", tbl_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_seq;
    t_bank;
    t_cond;
    t_jbit;
    t_djnz;
    t_jtf;
    t_jacc;
    t_table;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule